// File: doc/BRIEF.md
# D-Channel Byte Accumulator

This block moves signalling bits between a framed serial port and a host processor whose accesses are not aligned to the frame. In every frame the port gives one strobe carrying the signalling bits it received. The block collects those bits, least significant bit first, into a receive byte. On the same strobe it shifts the next bits of a transmit byte out towards the port.

A rate input selects how many bits move per strobe: two bits for the 16 kb/s rate or one bit for the 8 kb/s rate. When a whole byte has been exchanged, the block does three things on the completing strobe. It copies the collected byte into a read buffer, loads the host's most recent transmit byte into the shifter and raises an interrupt. The host then reads and writes the single data register while the next byte is being exchanged. Clearing the enable stops the exchange and sends idle ones.

Top module: `dch_accum`

## Requirements
- R1: The host reads the last completed receive byte on host_rdata_o. A host_wr_i pulse stores host_wdata_i as the byte to transmit.
- R2: With rate16_i=1, each strobe takes in two bits. rx_bits_i[0] lands at byte bit 2k and rx_bits_i[1] at bit 2k+1, where k counts strobes from 0. The byte completes on the 4th strobe.
- R3: With rate16_i=0, each strobe takes in only rx_bits_i[0], which lands at bit k. rx_bits_i[1] is ignored and tx_bits_o[1] is held at 1. The byte completes on the 8th strobe.
- R4: Transmit bits are presented before each strobe, least significant bit first. In 16 kb/s mode, tx_bits_o[0] carries byte bit 2k and tx_bits_o[1] carries bit 2k+1. In 8 kb/s mode, tx_bits_o[0] carries bit k.
- R5: irq_o rises in the cycle after a byte-completing strobe and not earlier. A host read or write clears it. If a set and a clear fall in the same cycle, the set wins.
- R6: A byte written by the host is sent starting with the byte after the next completion. If no new byte is written, the last transmit byte is sent again.
- R7: While enable_i=0, strobes are ignored, the frame counter returns to zero, irq_o is 0 and tx_bits_o is 2'b11. On re-enable, transmission starts from bit 0 of the stored transmit byte.
- R8: After reset, irq_o=0, host_rdata_o=8'h00 and the stored transmit byte is 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | D-channel function enable |
| rate16_i | input | 1 | 1: two bits per frame, 0: one bit per frame |
| bit_stb_i | input | 1 | One-cycle strobe per frame when the D-channel bits are present |
| rx_bits_i | input | 2 | Received bits for this frame; bit 0 is earlier |
| tx_bits_o | output | 2 | Bits to transmit at the next strobe; bit 0 is earlier |
| host_rd_i | input | 1 | Host read of the data register |
| host_wr_i | input | 1 | Host write of the data register |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Last completed receive byte |
| irq_o | output | 1 | Byte-exchange interrupt |

## Verification
The assertions assume three things about the inputs. First, rate16_i changes only while enable_i is low. Second, bit_stb_i is a single-cycle pulse. Third, a host access that is meant to clear the interrupt does not coincide with a strobe. The stimulus keeps within these limits: it switches rate only while disabled, spaces every strobe with an idle cycle, and issues host reads and writes only between frames. Received bytes go into a queue when a byte starts. A monitor pops each one when the interrupt rises, so a missing or early interrupt shows up as a mismatch.

// File: rtl/dch_pkg.sv
package dch_pkg;
  localparam logic [1:0] DCH_IDLE_BITS = 2'b11;
  localparam int unsigned DCH_MAX_BITS = 2;
endpackage

// File: rtl/dch_frame_ctr.sv
module dch_frame_ctr #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic stb_i,
  input  logic wide_i,
  output logic byte_done_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(BYTE_W / dch_pkg::DCH_MAX_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last        = wide_i ? LAST_WIDE : LAST_NARROW;
  assign byte_done_o = en_i && stb_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (byte_done_o) cnt_q <= '0;
    else if (stb_i)       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dch_rx_shift.sv
module dch_rx_shift #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              stb_i,
  input  logic              wide_i,
  input  logic [1:0]        bits_i,
  output logic [BYTE_W-1:0] next_o
);
  logic [BYTE_W-1:0] sh_q;

  // new bits enter at the top so the first bit ends at position 0
  assign next_o = wide_i ? {bits_i[1], bits_i[0], sh_q[BYTE_W-1:2]}
                         : {bits_i[0], sh_q[BYTE_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sh_q <= '0;
    else if (!en_i) sh_q <= '0;
    else if (stb_i) sh_q <= next_o;
  end
endmodule

// File: rtl/dch_tx_shift.sv
module dch_tx_shift #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              stb_i,
  input  logic              wide_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_data_i,
  output logic [1:0]        bits_o
);
  logic [BYTE_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             sh_q <= '1;
    else if (!en_i || load_i) sh_q <= load_data_i;
    else if (stb_i) begin
      if (wide_i) sh_q <= {2'b11, sh_q[BYTE_W-1:2]};
      else        sh_q <= {1'b1, sh_q[BYTE_W-1:1]};
    end
  end

  always_comb begin
    if (!en_i)       bits_o = dch_pkg::DCH_IDLE_BITS;
    else if (wide_i) bits_o = sh_q[1:0];
    else             bits_o = {1'b1, sh_q[0]};
  end
endmodule

// File: rtl/dch_host_if.sv
module dch_host_if #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      tx_byte_o <= '1;
      irq_o     <= 1'b0;
    end else begin
      if (wr_i) tx_byte_o <= wdata_i;
      if (byte_done_i) rdata_o <= rx_byte_i;
      if (!en_i)            irq_o <= 1'b0;
      else if (byte_done_i) irq_o <= 1'b1;
      else if (rd_i || wr_i) irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dch_accum.sv
module dch_accum #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              rate16_i,
  input  logic              bit_stb_i,
  input  logic [1:0]        rx_bits_i,
  output logic [1:0]        tx_bits_o,
  input  logic              host_rd_i,
  input  logic              host_wr_i,
  input  logic [BYTE_W-1:0] host_wdata_i,
  output logic [BYTE_W-1:0] host_rdata_o,
  output logic              irq_o
);
  logic              byte_done;
  logic [BYTE_W-1:0] rx_next;
  logic [BYTE_W-1:0] tx_byte;

  dch_frame_ctr #(.BYTE_W(BYTE_W)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(enable_i), .stb_i(bit_stb_i),
    .wide_i(rate16_i), .byte_done_o(byte_done)
  );

  dch_rx_shift #(.BYTE_W(BYTE_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(enable_i), .stb_i(bit_stb_i),
    .wide_i(rate16_i), .bits_i(rx_bits_i), .next_o(rx_next)
  );

  dch_tx_shift #(.BYTE_W(BYTE_W)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(enable_i), .stb_i(bit_stb_i),
    .wide_i(rate16_i), .load_i(byte_done), .load_data_i(tx_byte),
    .bits_o(tx_bits_o)
  );

  dch_host_if #(.BYTE_W(BYTE_W)) u_host (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(enable_i), .byte_done_i(byte_done),
    .rx_byte_i(rx_next), .rd_i(host_rd_i), .wr_i(host_wr_i),
    .wdata_i(host_wdata_i), .rdata_o(host_rdata_o), .tx_byte_o(tx_byte),
    .irq_o(irq_o)
  );
endmodule

// File: rtl/dch_accum_chk.sv
module dch_accum_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              rate16_i,
  input logic              bit_stb_i,
  input logic [1:0]        tx_bits_o,
  input logic              host_rd_i,
  input logic              host_wr_i,
  input logic [BYTE_W-1:0] host_rdata_o,
  input logic              irq_o
);
  p_idle_tx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> tx_bits_o == 2'b11);

  p_no_irq_when_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !irq_o);

  p_narrow_idle_lane_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rate16_i |-> tx_bits_o[1]);

  p_irq_from_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(bit_stb_i && enable_i));

  p_irq_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && (host_rd_i || host_wr_i) && !bit_stb_i |=> !irq_o);

  p_rdata_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_stb_i && enable_i) |=> $stable(host_rdata_o));
endmodule

bind dch_accum dch_accum_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .rate16_i(rate16_i),
  .bit_stb_i(bit_stb_i), .tx_bits_o(tx_bits_o), .host_rd_i(host_rd_i),
  .host_wr_i(host_wr_i), .host_rdata_o(host_rdata_o), .irq_o(irq_o)
);

// File: tb/tb_dch_accum.sv
`timescale 1ns/1ps
module tb_dch_accum;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enable_i = 1'b0;
  logic       rate16_i = 1'b1;
  logic       bit_stb_i = 1'b0;
  logic [1:0] rx_bits_i = 2'b00;
  logic [1:0] tx_bits_o;
  logic       host_rd_i = 1'b0;
  logic       host_wr_i = 1'b0;
  logic [7:0] host_wdata_i = 8'h00;
  logic [7:0] host_rdata_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk_i = ~clk_i;

  dch_accum dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .rate16_i(rate16_i),
    .bit_stb_i(bit_stb_i), .rx_bits_i(rx_bits_i), .tx_bits_o(tx_bits_o),
    .host_rd_i(host_rd_i), .host_wr_i(host_wr_i), .host_wdata_i(host_wdata_i),
    .host_rdata_o(host_rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one frame: check presented tx bits, then pulse the strobe
  task automatic frame(input logic [1:0] rx, input logic [1:0] exp_tx, input string req);
    @(negedge clk_i);
    chk(tx_bits_o === exp_tx, req, {6'b0, tx_bits_o}, {6'b0, exp_tx});
    rx_bits_i = rx;
    bit_stb_i = 1'b1;
    @(negedge clk_i);
    bit_stb_i = 1'b0;
  endtask

  // driver: pushes the expected receive byte, exchanges a whole byte
  task automatic send_byte(input logic [7:0] rx, input logic [7:0] tx, input string req);
    int n;
    n = rate16_i ? 4 : 8;
    exp_q.push_back(rx);
    for (int k = 0; k < n; k++) begin
      if (k == n - 1) chk(irq_o === 1'b0, "R5 early irq", {7'b0, irq_o}, 8'h00);
      if (rate16_i) frame({rx[2*k+1], rx[2*k]}, {tx[2*k+1], tx[2*k]}, req);
      else          frame({~rx[k], rx[k]}, {1'b1, tx[k]}, req);
    end
    chk(irq_o === 1'b1, "R5 irq set", {7'b0, irq_o}, 8'h01);
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk_i);
    host_wdata_i = d;
    host_wr_i = 1'b1;
    @(negedge clk_i);
    host_wr_i = 1'b0;
  endtask

  task automatic host_read();
    @(negedge clk_i);
    host_rd_i = 1'b1;
    @(negedge clk_i);
    host_rd_i = 1'b0;
  endtask

  // monitor: compare each completed byte against the scoreboard
  initial begin
    forever begin
      @(posedge irq_o);
      @(negedge clk_i);
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected byte", host_rdata_o, 8'hxx);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(host_rdata_o === e, "R1/R2/R3 rx byte", host_rdata_o, e);
      end
    end
  end

  initial begin
    #1ms;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R8 reset state
    chk(irq_o === 1'b0, "R8 irq", {7'b0, irq_o}, 8'h00);
    chk(host_rdata_o === 8'h00, "R8 rdata", host_rdata_o, 8'h00);
    chk(tx_bits_o === 2'b11, "R7 idle tx", {6'b0, tx_bits_o}, 8'h03);

    // R7 strobes ignored while disabled
    for (int k = 0; k < 5; k++) frame(2'b10, 2'b11, "R7 disabled tx");
    chk(irq_o === 1'b0, "R7 no irq", {7'b0, irq_o}, 8'h00);
    chk(host_rdata_o === 8'h00, "R7 rdata untouched", host_rdata_o, 8'h00);

    // R8 transmit default: enable without a write sends FF
    enable_i = 1'b1;
    send_byte(8'h96, 8'hFF, "R8 default tx");
    host_write(8'hA5);                 // R5 clear by write, R6 not yet used
    chk(irq_o === 1'b0, "R5 clear by write", {7'b0, irq_o}, 8'h00);

    // R6 write lands after the next completion; R2/R4 wide packing
    send_byte(8'h3C, 8'hFF, "R6 old byte");
    host_read();
    chk(irq_o === 1'b0, "R5 clear by read", {7'b0, irq_o}, 8'h00);
    send_byte(8'hC3, 8'hA5, "R4 wide tx");
    host_read();
    send_byte(8'h81, 8'hA5, "R6 repeat tx");

    // R7 disable clears irq and idles tx
    @(negedge clk_i);
    enable_i = 1'b0;
    @(negedge clk_i);
    chk(irq_o === 1'b0, "R7 irq cleared", {7'b0, irq_o}, 8'h00);
    chk(tx_bits_o === 2'b11, "R7 idle tx", {6'b0, tx_bits_o}, 8'h03);

    // R3 narrow mode, with partial byte aborted by disable
    rate16_i = 1'b0;
    host_write(8'h4B);
    @(negedge clk_i);
    enable_i = 1'b1;
    frame(2'b01, 2'b11, "R3 partial");   // 4B bit0=1
    frame(2'b00, 2'b11, "R3 partial");   // bit1=1
    frame(2'b01, 2'b10, "R3 partial");   // bit2=0
    @(negedge clk_i);
    enable_i = 1'b0;
    @(negedge clk_i);
    enable_i = 1'b1;
    send_byte(8'h5B, 8'h4B, "R3 narrow tx");
    host_read();
    send_byte(8'hE2, 8'h4B, "R3 repeat narrow");

    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R1 all bytes seen", 8'(exp_q.size()), 8'h00);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule